// File: doc/BRIEF.md
# Dual Fractional Sample-Rate Strobe Generator

This block turns one master clock, running at 256 times a reference sample rate, into two independent sample strobes: one for the capture (ADC) path and one for the playback (DAC) path. Each path divides the reference rate by a ratio N that runs from 1 to 6 in steps of one half. A per-path double-rate bit selects twice that rate. Because both paths run from the same master clock but keep their own counters, the two sample rates can differ. With a 44.1 kHz reference and N = 5.5, for example, a path runs at about 8.018 kHz.

Each path also drives a word clock of its own. The word clock is high for the first half of every sample period and low for the second half. When the two rates differ, the capture side therefore has a frame marker separate from the playback side. Each strobe is a one-cycle clock enable, so downstream logic stays in the master-clock domain. A new ratio setting is sampled at the end of the current period, so a period is never cut short or stretched.

Top module: `dual_rate_strobe_gen`

## Requirements
- R1: While `rst` is high, all four outputs are low on the cycle after each reset edge.
- R2: The ratio code k equals 2N−2. Codes 0 to 10 give N = 1 to 6. With the double-rate bit low, strobes on a path are 128 × (k + 2) master clocks apart.
- R3: With the double-rate bit high, strobes on a path are 64 × (k + 2) master clocks apart.
- R4: Codes 11 to 15 behave exactly like code 0.
- R5: Each strobe is high for exactly one master clock per period.
- R6: A word clock is high in the strobe cycle and for the first half of the period, P/2 cycles in total. It is low for the remaining P/2 cycles.
- R7: A settings change made during a period does not alter that period. The interval up to the next strobe uses the old setting, and the interval after it uses the new one.
- R8: The settings of one path have no effect on the timing of the other path's strobe.
- R9: After reset is released, the first strobe of a path comes P master clocks later, where P is that path's period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock at 256 × reference rate |
| rst | input | 1 | Synchronous active-high reset |
| adc_ratio | input | 4 | Capture path ratio code k = 2N−2 |
| adc_double | input | 1 | Capture path double-rate select |
| dac_ratio | input | 4 | Playback path ratio code k = 2N−2 |
| dac_double | input | 1 | Playback path double-rate select |
| adc_strobe | output | 1 | Capture path one-cycle sample enable |
| adc_wclk | output | 1 | Capture path word clock |
| dac_strobe | output | 1 | Playback path one-cycle sample enable |
| dac_wclk | output | 1 | Playback path word clock |

## Verification
A corrupted counter or latched period shows up at the ports as a strobe interval of the wrong length, and it is visible at the very next strobe, at most 1536 master clocks later. A wrong half-period compare shifts the falling edge of the word clock. Measuring the high time over each full period exposes it within one period. Cross-coupling between the paths, or a setting applied mid-period, distorts exactly one measured interval, and the bench checks that interval on both sides of a change.

// File: rtl/srs_pkg.sv
package srs_pkg;
  parameter int CODE_W   = 4;
  parameter int MAX_CODE = 10;
  parameter int UNIT     = 64;
  localparam int MAX_PERIOD = 2 * UNIT * (MAX_CODE + 2);
  localparam int PER_W      = $clog2(MAX_PERIOD + 1);
  typedef logic [PER_W-1:0] period_t;
endpackage

// File: rtl/srs_ratio_decode.sv
// Maps a half-step ratio code and double-rate flag to a period in master clocks.
module srs_ratio_decode #(
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 10,
  parameter int UNIT     = 64,
  parameter int PER_W    = 11
) (
  input  logic [CODE_W-1:0] code,
  input  logic              dbl,
  output logic [PER_W-1:0]  period
);
  logic [PER_W-1:0] k_eff;
  logic [PER_W-1:0] base;

  always_comb begin
    k_eff  = (int'(code) > MAX_CODE) ? '0 : PER_W'(code);
    base   = (k_eff + PER_W'(2)) * PER_W'(UNIT);
    period = dbl ? base : (base << 1);
  end
endmodule

// File: rtl/srs_path_div.sv
// One path: counts a period, reloads the setting at wrap, registers strobe and word clock.
module srs_path_div #(
  parameter int PER_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] next_period,
  output logic             strobe_o,
  output logic             wclk_o
);
  logic [PER_W-1:0] cnt_q, per_q, cnt_nxt, per_nxt;
  logic             wrap;

  always_comb begin
    wrap    = (cnt_q == per_q - PER_W'(1));
    per_nxt = wrap ? next_period : per_q;
    cnt_nxt = wrap ? '0 : cnt_q + PER_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      per_q    <= next_period;
      strobe_o <= 1'b0;
      wclk_o   <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      per_q    <= per_nxt;
      strobe_o <= wrap;
      wclk_o   <= (cnt_nxt < (per_nxt >> 1));
    end
  end
endmodule

// File: rtl/dual_rate_strobe_gen.sv
module dual_rate_strobe_gen #(
  parameter int CODE_W   = srs_pkg::CODE_W,
  parameter int MAX_CODE = srs_pkg::MAX_CODE,
  parameter int UNIT     = srs_pkg::UNIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] adc_ratio,
  input  logic              adc_double,
  input  logic [CODE_W-1:0] dac_ratio,
  input  logic              dac_double,
  output logic              adc_strobe,
  output logic              adc_wclk,
  output logic              dac_strobe,
  output logic              dac_wclk
);
  localparam int NPATH = 2;
  localparam int PER_W = $clog2(2 * UNIT * (MAX_CODE + 2) + 1);

  logic [CODE_W-1:0] code_a [NPATH];
  logic [NPATH-1:0]  dbl_a, strb_a, wclk_a;

  assign code_a[0] = adc_ratio;
  assign code_a[1] = dac_ratio;
  assign dbl_a     = {dac_double, adc_double};

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    logic [PER_W-1:0] period;

    srs_ratio_decode #(
      .CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .UNIT(UNIT), .PER_W(PER_W)
    ) u_dec (
      .code(code_a[p]), .dbl(dbl_a[p]), .period(period)
    );

    srs_path_div #(.PER_W(PER_W)) u_div (
      .clk(clk), .rst(rst), .next_period(period),
      .strobe_o(strb_a[p]), .wclk_o(wclk_a[p])
    );
  end

  assign adc_strobe = strb_a[0];
  assign adc_wclk   = wclk_a[0];
  assign dac_strobe = strb_a[1];
  assign dac_wclk   = wclk_a[1];
endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int MIN_P = 128,
  parameter int MAX_P = 1536,
  parameter int GAP_W = 12
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] strobe,
  input logic [1:0] wclk
);
  for (genvar p = 0; p < 2; p++) begin : g_chk
    logic [GAP_W-1:0] gap;
    logic             seen;

    always_ff @(posedge clk) begin
      if (rst) begin
        gap  <= '0;
        seen <= 1'b0;
      end else if (strobe[p]) begin
        gap  <= '0;
        seen <= 1'b1;
      end else if (gap != '1) begin
        gap  <= gap + GAP_W'(1);
      end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!strobe[p] && !wclk[p])); // R1
    AST_GAP_MAX: assert property (@(posedge clk) disable iff (rst)
      strobe[p] |-> (int'(gap) <= MAX_P - 1)); // R2
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
      (strobe[p] && seen) |-> (int'(gap) >= MIN_P - 1)); // R3
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      strobe[p] |=> !strobe[p]); // R5
    AST_WCLK_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
      strobe[p] |-> wclk[p]); // R6
    AST_WCLK_LOW_AT_END: assert property (@(posedge clk) disable iff (rst)
      (strobe[p] && seen) |-> !$past(wclk[p])); // R6
  end
endmodule

bind dual_rate_strobe_gen srs_checker #(
  .MIN_P(2 * UNIT),
  .MAX_P(2 * UNIT * (MAX_CODE + 2)),
  .GAP_W(12)
) u_chk (
  .clk(clk), .rst(rst),
  .strobe({dac_strobe, adc_strobe}),
  .wclk({dac_wclk, adc_wclk})
);

// File: tb/dual_rate_strobe_gen_bench.sv
module dual_rate_strobe_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] adc_ratio = '0, dac_ratio = '0;
  logic       adc_double = 1'b0, dac_double = 1'b0;
  logic       adc_strobe, adc_wclk, dac_strobe, dac_wclk;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  dual_rate_strobe_gen u_dual_rate_strobe_gen (
    .clk(clk), .rst(rst),
    .adc_ratio(adc_ratio), .adc_double(adc_double),
    .dac_ratio(dac_ratio), .dac_double(dac_double),
    .adc_strobe(adc_strobe), .adc_wclk(adc_wclk),
    .dac_strobe(dac_strobe), .dac_wclk(dac_wclk)
  );

  function automatic logic strb(input int p);
    return p == 0 ? adc_strobe : dac_strobe;
  endfunction
  function automatic logic wck(input int p);
    return p == 0 ? adc_wclk : dac_wclk;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_path(input int p, input logic [3:0] code, input logic dbl);
    if (p == 0) begin adc_ratio = code; adc_double = dbl; end
    else        begin dac_ratio = code; dac_double = dbl; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check({adc_strobe, adc_wclk, dac_strobe, dac_wclk} == 4'b0, "R1", "outputs in reset",
          int'({adc_strobe, adc_wclk, dac_strobe, dac_wclk}), 0);
    rst = 1'b0;
  endtask

  // Counts negedges from now until the path's strobe is seen high.
  task automatic wait_strobe(input int p, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!strb(p) && n < 4000);
    if (!strb(p)) check(1'b0, "R2", "strobe timeout", n, 0);
  endtask

  task automatic measure(input int p, output int per, output int highs, output int pulses);
    int d;
    wait_strobe(p, d);
    per = 0; highs = 0; pulses = 0;
    do begin
      if (wck(p)) highs++;
      if (strb(p)) pulses++;
      @(negedge clk);
      per++;
    end while (!strb(p) && per < 4000);
  endtask

  task automatic t_period(input int p, input logic [3:0] code, input logic dbl,
                          input int exp, input string req);
    int per, highs, pulses;
    set_path(p, code, dbl);
    do_reset();
    measure(p, per, highs, pulses);
    check(per == exp, req, $sformatf("path%0d code%0d dbl%0d period", p, code, dbl), per, exp);
    check(highs == exp / 2, "R6", "word clock high time", highs, exp / 2);
    check(pulses == 1, "R5", "strobe cycles per period", pulses, 1);
  endtask

  task automatic t_first_strobe();
    int n, na, nd;
    set_path(0, 4'd0, 1'b0);   // 256
    set_path(1, 4'd2, 1'b0);   // 512
    do_reset();
    n = 0; na = 0; nd = 0;
    while ((na == 0 || nd == 0) && n < 4000) begin
      @(negedge clk);
      n++;
      if (adc_strobe && na == 0) na = n;
      if (dac_strobe && nd == 0) nd = n;
    end
    check(na == 256, "R9", "adc first strobe delay", na, 256);
    check(nd == 512, "R9", "dac first strobe delay", nd, 512);
  endtask

  task automatic t_change();
    int n;
    set_path(0, 4'd2, 1'b0);   // 512
    do_reset();
    wait_strobe(0, n);
    repeat (10) @(negedge clk);
    set_path(0, 4'd0, 1'b1);   // 128 from the next boundary
    wait_strobe(0, n);
    check(n == 502, "R7", "rest of period after change", n, 502);
    wait_strobe(0, n);
    check(n == 128, "R7", "first period with new setting", n, 128);
  endtask

  task automatic t_indep();
    int n;
    set_path(1, 4'd4, 1'b0);   // 768
    set_path(0, 4'd1, 1'b0);   // 384
    do_reset();
    wait_strobe(1, n);
    repeat (100) @(negedge clk);
    set_path(0, 4'd7, 1'b1);
    repeat (100) @(negedge clk);
    set_path(0, 4'd12, 1'b0);
    wait_strobe(1, n);
    check(n == 568, "R8", "dac interval with adc changing", n + 200, 768);
    wait_strobe(1, n);
    check(n == 768, "R8", "dac next interval", n, 768);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_first_strobe();
    t_period(0, 4'd9,  1'b0, 1408, "R2");  // N = 5.5
    t_period(1, 4'd3,  1'b0, 640,  "R2");  // N = 2.5
    t_period(0, 4'd10, 1'b1, 768,  "R3");  // N = 6, double
    t_period(1, 4'd0,  1'b1, 128,  "R3");  // N = 1, double
    t_period(0, 4'd13, 1'b0, 256,  "R4");
    t_period(1, 4'd15, 1'b1, 128,  "R4");
    t_change();
    t_indep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule